// File: doc/BRIEF.md
# DMA Bus Cycle Sequencer

This block is the bus-master engine of a DMA controller. An arbiter outside it picks a channel and presents a pending request together with the channel number and a transfer kind. The sequencer then raises a hold request toward the processor and waits for the grant. Once it has the grant, it takes the bus and runs byte cycles. Each cycle moves through an address phase, a strobe phase, optional wait states and a closing phase. After the last cycle it hands the bus back.

In the address phase, the upper half of the working address goes out on the shared data pins with a one-cycle strobe so that an external latch can capture it. The lower half stays on the address pins for the whole cycle. The kind of transfer selects which read/write strobe pair is pulled low. The verify kind pulls no strobe at all, but it still acknowledges the channel. A READY input, passed through a two-stage synchronizer, stretches the strobe phase. In single-byte mode the hold request is dropped after every byte. In burst mode it is kept until the terminal count is reached or the request goes away.

The working address and remaining count are loaded from the register side. The sequencer itself advances them at the end of every cycle.

Top module: `dma_bus_seq`

## Requirements
- R1: After `reqValid` rises, `hrq` goes high. `aen`, `adstb`, every strobe and every `dackN` bit stay inactive until `hlda` has been seen high.
- R2: Every bus cycle starts with exactly one clock of `adstb` high. In that clock `dataOe` is high and `dataOut` carries address bits 15..8, while `addrLo` carries address bits 7..0.
- R3: `aen` and `ctlOe` are high exactly while the block owns the bus. Outside ownership, `iorN`, `iowN`, `memrN` and `memwN` are all high.
- R4: Transfer kind 2'b01 (peripheral to memory) drives `iorN` and `memwN` low together, and `iowN` and `memrN` stay high.
- R5: Transfer kind 2'b10 (memory to peripheral) drives `memrN` and `iowN` low together, and `iorN` and `memwN` stay high.
- R6: Transfer kinds 2'b00 (verify) and 2'b11 run full bus cycles with the channel acknowledged, but no strobe goes low.
- R7: With READY high, the strobes stay low for exactly two clocks per cycle. Each clock in which the synchronized READY is low adds one wait clock. If READY rises two clocks after the strobes fall, the strobes stay low for six clocks.
- R8: Each cycle uses the current working address. The address then steps up by one, with carry into the upper byte, and the count steps down by one. `tc` is high during a cycle whose count is zero.
- R9: In single-byte mode (`burstMode`=0), `hrq` falls after every cycle, so each byte needs a fresh hold handshake.
- R10: In burst mode, `hrq` stays high between cycles. The burst ends after the cycle that carries `tc`, or after the cycle in whose closing phase `reqValid` is low.
- R11: `dackN` is active low and one-hot on the channel captured when the request was accepted. It is asserted only while the bus is owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Arbitrated request pending |
| reqChan | input | 2 | Channel number of the request |
| xferType | input | 2 | Transfer kind (00 verify, 01 write, 10 read, 11 verify) |
| burstMode | input | 1 | 1 = burst, 0 = single byte |
| loadEn | input | 1 | Load working address and count |
| loadAddr | input | 16 | Address to load |
| loadCount | input | 14 | Cycles minus one to load |
| hlda | input | 1 | Hold acknowledge from processor |
| ready | input | 1 | Asynchronous memory ready |
| hrq | output | 1 | Hold request |
| aen | output | 1 | Address enable / bus owned |
| adstb | output | 1 | Upper-address strobe |
| dataOut | output | 8 | Upper address byte on data pins |
| dataOe | output | 1 | Data pin drive enable |
| addrLo | output | 8 | Lower address byte |
| addrOe | output | 1 | Address pin drive enable |
| ctlOe | output | 1 | Strobe pin drive enable |
| iorN | output | 1 | I/O read, active low |
| iowN | output | 1 | I/O write, active low |
| memrN | output | 1 | Memory read, active low |
| memwN | output | 1 | Memory write, active low |
| dackN | output | 4 | Channel acknowledge, active low |
| tc | output | 1 | Terminal count cycle |

## Verification
The sequencer is driven with six request patterns:
- a lone write byte;
- a three-byte single-mode read across a 0xFF address boundary;
- a write burst that ends at terminal count;
- a verify burst ended early by dropping the request;
- a reserved-kind byte;
- a read held off by READY.

The first three separate single-byte from burst hold behaviour and check the address carry. The verify and reserved cases separate the acknowledge from the strobes. The READY case pins the exact wait-state count through the synchronizer. The per-cycle records compare the latched address, channel, strobe pair, strobe width, terminal count and whether a new hold handshake came first.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_S1, ST_S2, ST_SW, ST_S3, ST_S4
  } seqState_t;

  typedef enum logic [1:0] {
    XF_VERIFY = 2'b00,
    XF_WRITE  = 2'b01,
    XF_READ   = 2'b10,
    XF_RSVD   = 2'b11
  } xferKind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic latchReq;   // capture channel and kind
    logic own;        // bus owned (S1..S4)
    logic addrPhase;  // S1
    logic strobeOn;   // S2, SW, S3
    logic step;       // S4: advance address and count
  } seqCtl_t;

endpackage

// File: rtl/dma_seq_ctl.sv
module dma_seq_ctl
  import dma_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    burstMode,
  input  logic    hlda,
  input  logic    ready,
  input  logic    tcNow,
  output logic    hrq,
  output seqCtl_t ctl
);

  logic [SYNC_STAGES-1:0] readySh;
  logic                   readyS;
  seqState_t              state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readySh <= '0;
    else       readySh <= {readySh[SYNC_STAGES-2:0], ready};
  end
  assign readyS = readySh[SYNC_STAGES-1];

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_HOLD;
      ST_HOLD: if (hlda)     stateNext = ST_S1;
      ST_S1:   stateNext = ST_S2;
      ST_S2:   stateNext = readyS ? ST_S3 : ST_SW;
      ST_SW:   if (readyS)   stateNext = ST_S3;
      ST_S3:   stateNext = ST_S4;
      ST_S4:   stateNext = (burstMode && reqValid && !tcNow) ? ST_S1 : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign hrq           = (state != ST_IDLE);
  assign ctl.latchReq  = (state == ST_IDLE) && reqValid;
  assign ctl.own       = (state == ST_S1) || (state == ST_S2) || (state == ST_SW) ||
                         (state == ST_S3) || (state == ST_S4);
  assign ctl.addrPhase = (state == ST_S1);
  assign ctl.strobeOn  = (state == ST_S2) || (state == ST_SW) || (state == ST_S3);
  assign ctl.step      = (state == ST_S4);

endmodule

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 14,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int HALF = AW / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCtl_t            ctl,
  input  logic [CHW-1:0]     reqChan,
  input  logic [1:0]         xferType,
  input  logic               loadEn,
  input  logic [AW-1:0]      loadAddr,
  input  logic [CW-1:0]      loadCount,
  output logic               tcNow,
  output logic               aen,
  output logic               adstb,
  output logic [AW-HALF-1:0] dataOut,
  output logic               dataOe,
  output logic [HALF-1:0]    addrLo,
  output logic               addrOe,
  output logic               ctlOe,
  output logic               iorN,
  output logic               iowN,
  output logic               memrN,
  output logic               memwN,
  output logic [NCH-1:0]     dackN,
  output logic               tc
);

  logic [AW-1:0]  workAddr;
  logic [CW-1:0]  workCount;
  logic [CHW-1:0] chanLat;
  xferKind_t      kindLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workAddr  <= '0;
      workCount <= '0;
      chanLat   <= '0;
      kindLat   <= XF_VERIFY;
    end else begin
      if (loadEn) begin
        workAddr  <= loadAddr;
        workCount <= loadCount;
      end else if (ctl.step) begin
        workAddr  <= workAddr + 1'b1;
        workCount <= workCount - 1'b1;
      end
      if (ctl.latchReq) begin
        chanLat <= reqChan;
        kindLat <= xferKind_t'(xferType);
      end
    end
  end

  assign tcNow   = (workCount == '0);
  assign tc      = ctl.own && tcNow;
  assign aen     = ctl.own;
  assign ctlOe   = ctl.own;
  assign addrOe  = ctl.own;
  assign adstb   = ctl.addrPhase;
  assign dataOe  = ctl.addrPhase;
  assign dataOut = workAddr[AW-1:HALF];
  assign addrLo  = workAddr[HALF-1:0];

  logic ioToMem, memToIo;
  assign ioToMem = ctl.strobeOn && (kindLat == XF_WRITE);
  assign memToIo = ctl.strobeOn && (kindLat == XF_READ);
  assign iorN    = ~ioToMem;
  assign memwN   = ~ioToMem;
  assign memrN   = ~memToIo;
  assign iowN    = ~memToIo;

  for (genvar i = 0; i < NCH; i++) begin : g_dack
    assign dackN[i] = ~(ctl.own && (chanLat == CHW'(i)));
  end

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 14,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int HALF = AW / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [CHW-1:0]     reqChan,
  input  logic [1:0]         xferType,
  input  logic               burstMode,
  input  logic               loadEn,
  input  logic [AW-1:0]      loadAddr,
  input  logic [CW-1:0]      loadCount,
  input  logic               hlda,
  input  logic               ready,
  output logic               hrq,
  output logic               aen,
  output logic               adstb,
  output logic [AW-HALF-1:0] dataOut,
  output logic               dataOe,
  output logic [HALF-1:0]    addrLo,
  output logic               addrOe,
  output logic               ctlOe,
  output logic               iorN,
  output logic               iowN,
  output logic               memrN,
  output logic               memwN,
  output logic [NCH-1:0]     dackN,
  output logic               tc
);

  seqCtl_t ctl;
  logic    tcNow;

  dma_seq_ctl #(.SYNC_STAGES(2)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .burstMode(burstMode),
    .hlda(hlda), .ready(ready), .tcNow(tcNow), .hrq(hrq), .ctl(ctl)
  );

  dma_seq_dp #(.NCH(NCH), .AW(AW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqChan(reqChan), .xferType(xferType),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadCount(loadCount), .tcNow(tcNow),
    .aen(aen), .adstb(adstb), .dataOut(dataOut), .dataOe(dataOe),
    .addrLo(addrLo), .addrOe(addrOe), .ctlOe(ctlOe), .iorN(iorN), .iowN(iowN),
    .memrN(memrN), .memwN(memwN), .dackN(dackN), .tc(tc)
  );

endmodule

// File: rtl/dma_bus_seq_chk.sv
module dma_bus_seq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           hlda,
  input logic           hrq,
  input logic           aen,
  input logic           adstb,
  input logic           ctlOe,
  input logic           iorN,
  input logic           iowN,
  input logic           memrN,
  input logic           memwN,
  input logic [NCH-1:0] dackN
);

  // R1: bus taken only after the grant was seen
  p_grant_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aen) |-> $past(hlda));
  // R1: ownership implies the hold request is up
  p_own_needs_hrq_r1: assert property (@(posedge clk) disable iff (!rstN)
    aen |-> hrq);
  // R2: address strobe is a single clock
  p_adstb_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    adstb |=> !adstb);
  // R3: strobes idle and undriven when not owner
  p_idle_strobes_r3: assert property (@(posedge clk) disable iff (!rstN)
    !aen |-> (iorN && iowN && memrN && memwN && !ctlOe));
  // R4: I/O read pairs with memory write
  p_write_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    !iorN |-> (!memwN && iowN && memrN));
  // R5: memory read pairs with I/O write
  p_read_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memrN |-> (!iowN && iorN && memwN));
  // R11: at most one acknowledge, only while owner
  p_dack_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~dackN));
  p_dack_owner_r11: assert property (@(posedge clk) disable iff (!rstN)
    (~dackN != '0) |-> aen);

endmodule

bind dma_bus_seq dma_bus_seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .hlda(hlda), .hrq(hrq), .aen(aen), .adstb(adstb),
  .ctlOe(ctlOe), .iorN(iorN), .iowN(iowN), .memrN(memrN), .memwN(memwN),
  .dackN(dackN)
);

// File: tb/sim_dma_bus_seq.sv
module sim_dma_bus_seq;

  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic [1:0]  reqChan = 0;
  logic [1:0]  xferType = 0;
  logic        burstMode = 0;
  logic        loadEn = 0;
  logic [15:0] loadAddr = 0;
  logic [13:0] loadCount = 0;
  logic        hlda = 0;
  logic        ready = 1;
  logic        hrq, aen, adstb, dataOe, addrOe, ctlOe, iorN, iowN, memrN, memwN, tc;
  logic [7:0]  dataOut, addrLo;
  logic [3:0]  dackN;

  always #2.5 clk = ~clk;

  dma_bus_seq u0 (.*);

  typedef struct {
    int addr; int chan; int pat; int width; int tcv; int newHold;
  } cyc_t;

  cyc_t expQ[$];
  int   vecCnt = 0;
  int   failCnt = 0;
  bit   done = 0;

  task automatic chk(string req, string what, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pushExp(int addr, int chan, int pat, int width, int tcv, int newHold);
    cyc_t e;
    e.addr = addr; e.chan = chan; e.pat = pat; e.width = width;
    e.tcv = tcv; e.newHold = newHold;
    expQ.push_back(e);
  endtask

  // processor model: grant three clocks after hrq, release at once
  int hCnt = 0;
  always @(negedge clk) begin
    if (!hrq) begin hlda <= 0; hCnt <= 0; end
    else if (hCnt < 3) hCnt <= hCnt + 1;
    else hlda <= 1;
  end

  // monitor
  bit   inCyc = 0, holdSeenLow = 1, ownNoGrant = 0;
  cyc_t cur;

  function automatic int chanOf(logic [3:0] d);
    for (int i = 0; i < 4; i++) if (!d[i]) return i;
    return 99;
  endfunction

  task automatic closeCyc();
    cyc_t e;
    inCyc = 0;
    if (expQ.size() == 0) begin
      chk("R10", "unexpected bus cycle", 1, 0);
      return;
    end
    e = expQ.pop_front();
    chk("R2/R8", "cycle address", cur.addr, e.addr);
    chk("R11", "acknowledged channel", cur.chan, e.chan);
    chk("R4/R5/R6", "strobe pattern {ior,iow,memr,memw}", cur.pat, e.pat);
    chk("R7", "strobe low clocks", cur.width, e.width);
    chk("R8", "tc", cur.tcv, e.tcv);
    chk("R9/R10", "new hold handshake", cur.newHold, e.newHold);
    chk("R1", "owned without grant", int'(ownNoGrant), 0);
    ownNoGrant = 0;
  endtask

  initial begin
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (aen && !hlda) ownNoGrant = 1;
      if (inCyc && (adstb || !aen)) closeCyc();
      if (adstb) begin
        inCyc = 1;
        cur.addr = {dataOut, addrLo};
        cur.chan = chanOf(dackN);
        cur.tcv = tc;
        cur.newHold = holdSeenLow;
        cur.pat = 4'hF; cur.width = 0;
        holdSeenLow = 0;
        chk("R2", "dataOe during address strobe", dataOe, 1);
      end
      if (inCyc) begin
        cur.pat &= {iorN, iowN, memrN, memwN};
        if ({iorN, iowN, memrN, memwN} != 4'hF) cur.width++;
      end
      if (!hrq) holdSeenLow = 1;
    end
  end

  task automatic loadWork(logic [15:0] a, logic [13:0] c);
    @(negedge clk); loadEn = 1; loadAddr = a; loadCount = c;
    @(negedge clk); loadEn = 0;
  endtask

  task automatic waitHoldEnds(int n);
    for (int k = 0; k < n; k++) begin
      while (!hrq) @(negedge clk);
      while (hrq) @(negedge clk);
    end
  endtask

  task automatic startReq(int chan, int kind, bit burst);
    reqChan = 2'(chan); xferType = 2'(kind); burstMode = burst; reqValid = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // reset state
    chk("R9", "hrq in reset", hrq, 0);
    chk("R3", "aen in reset", aen, 0);
    chk("R3", "ctlOe in reset", ctlOe, 0);
    chk("R3", "strobes in reset", {iorN, iowN, memrN, memwN}, 4'hF);
    chk("R11", "dackN in reset", dackN, 4'hF);
    chk("R2", "adstb in reset", adstb, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R4: single write byte
    loadWork(16'h12F0, 14'd5);
    pushExp(16'h12F0, 2, 4'b0110, 2, 0, 1);
    startReq(2, 1, 0);
    while (!hrq) @(negedge clk);
    chk("R1", "aen while waiting for grant", aen, 0);
    waitHoldEnds(1); reqValid = 0;
    repeat (3) @(negedge clk);

    // R5 R9: three single reads across byte carry
    loadWork(16'h34FE, 14'd7);
    pushExp(16'h34FE, 1, 4'b1001, 2, 0, 1);
    pushExp(16'h34FF, 1, 4'b1001, 2, 0, 1);
    pushExp(16'h3500, 1, 4'b1001, 2, 0, 1);
    startReq(1, 2, 0);
    waitHoldEnds(3); reqValid = 0;
    repeat (3) @(negedge clk);

    // R10: write burst ending at terminal count
    loadWork(16'hABCD, 14'd2);
    pushExp(16'hABCD, 0, 4'b0110, 2, 0, 1);
    pushExp(16'hABCE, 0, 4'b0110, 2, 0, 0);
    pushExp(16'hABCF, 0, 4'b0110, 2, 1, 0);
    startReq(0, 1, 1);
    waitHoldEnds(1); reqValid = 0;
    repeat (3) @(negedge clk);

    // R6 R10: verify burst cut short by dropping request
    loadWork(16'h0100, 14'd20);
    pushExp(16'h0100, 3, 4'hF, 0, 0, 1);
    pushExp(16'h0101, 3, 4'hF, 0, 0, 0);
    startReq(3, 0, 1);
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      while (!adstb) @(negedge clk);
    end
    reqValid = 0;
    while (hrq) @(negedge clk);
    repeat (3) @(negedge clk);

    // R6: reserved kind behaves as verify
    loadWork(16'h00FF, 14'd0);
    pushExp(16'h00FF, 0, 4'hF, 0, 1, 1);
    startReq(0, 3, 0);
    waitHoldEnds(1); reqValid = 0;
    repeat (3) @(negedge clk);

    // R7: READY low, released two clocks after strobes fall
    ready = 0;
    repeat (4) @(negedge clk);
    loadWork(16'hFFFF, 14'd0);
    pushExp(16'hFFFF, 1, 4'b1001, 6, 1, 1);
    startReq(1, 2, 0);
    while ({iorN, iowN, memrN, memwN} == 4'hF) @(negedge clk);
    repeat (2) @(negedge clk);
    ready = 1;
    while (hrq) @(negedge clk);
    reqValid = 0;
    repeat (6) @(negedge clk);

    chk("R10", "expected cycles left over", expQ.size(), 0);
    chk("R3", "aen after all traffic", aen, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

endmodule